// File: doc/BRIEF.md
# Pipelined Write Store Cache

This block is a direct-mapped, write-through data cache controller. It splits every store into two steps. In the first step the store's tag is compared against the line it indexes. In the second step the store's data is written into the data array. The second step takes place while a later operation is being handled, so a store hit costs the CPU a single cycle even though the array has only one write port. A store that has passed its tag check but has not yet reached the array waits in a one-entry delayed-write register. Loads do not pass through this two-step path. Instead, every load compares its address against the delayed-write register. When the addresses match, the load takes the newer value from the register.

Every accepted store is also placed in a one-entry write buffer that drains to the lower-level memory, which keeps that memory current. A miss on a load or a store stalls the CPU. While the miss is handled, the delayed-write register is committed, the write buffer is drained, and the one-word line is fetched into the array. After that the stalled request is presented to the tag check again.

Top module: `store_pipe_cache`

## Requirements
- R1: After reset, `cpuReady` is high when no request is presented, `memReq` is low, and every line is invalid, so the first load to any address issues a memory read.
- R2: A load that hits is accepted in the cycle it is presented (`cpuReady` high, `cpuWe`=0), and `cpuRdata` in that cycle carries the newest value stored at that address.
- R3: A store hit (`cpuWe`=1), presented while the write buffer has room, is accepted in the same cycle. Its data reaches the array only when one of three events occurs: the next store is accepted, a load to the same address is accepted, or a miss is detected.
- R4: A load whose address equals the pending delayed-write address returns the pending data with no stall. The pending write is committed to the array in that same cycle.
- R5: A load to a different address leaves the pending store in place, and that store's value is still returned by later loads.
- R6: On a miss, `cpuReady` stays low, and the pending store is committed before the line fill begins. The fill read is issued only when no memory write is outstanding, so it never returns data older than an accepted store.
- R7: A store miss first fills its line from memory. It then retries the tag check and completes as a hit, and later loads return the stored value.
- R8: Every accepted store causes exactly one memory write (`memWe`=1) with its word address and data. After the writes drain, the lower-level memory matches every store.
- R9: Once raised, `memReq` with its `memWe`, `memAddr` and `memWdata` stays unchanged until the cycle in which `memAck` is high.
- R10: The write buffer holds one store. A store hit that arrives while an earlier write is still unacknowledged is stalled until that write's `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpuValid | input | 1 | CPU request present; held with its fields until accepted |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Word address; low INDEX_W bits select the line |
| cpuWdata | input | DATA_W | Store data |
| cpuReady | output | 1 | Request accepted at the next rising edge |
| cpuRdata | output | DATA_W | Load data, valid while cpuReady is high for a load |
| memReq | output | 1 | Lower-level request |
| memWe | output | 1 | 1 = write from the buffer, 0 = line fill read |
| memAddr | output | ADDR_W | Lower-level word address |
| memWdata | output | DATA_W | Lower-level write data |
| memAck | input | 1 | One-cycle completion of the current request |
| memRdata | input | DATA_W | Fill data, valid with memAck on a read |

## Verification
The assertions check several rules on every cycle. A pending delayed write always belongs to a resident line. No delayed write survives into miss service. A fill read is never issued while a buffered write is outstanding. Both the write buffer and the memory request hold steady until acknowledged. Data correctness can only be shown by the bench's scenarios, which compare each load against a flat reference memory: forwarding from the pending store, the commit at a conflicting miss, store-miss allocation, and the final agreement of the lower-level memory with every store. The bench also measures stall counts, which show the single-cycle store hit and the write-buffer back-pressure.

// File: rtl/spc_pkg.sv
package spc_pkg;

  // Strobes sent from the control unit to the datapath.
  typedef struct packed {
    logic arrWr;       // write one word into the data array
    logic arrFromMem;  // array write source: 1 = fill data, 0 = delayed store
    logic dwrLoad;     // capture the current store into the delayed-write register
    logic dwrClr;      // retire the delayed-write register
    logic wbPush;      // place the current store into the write buffer
    logic lineFill;    // mark the requested line valid with the request tag
  } spcStrobe_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FILL  = 2'd2
  } spcState_e;

endpackage

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  spcStrobe_t        ctl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              lineHit,
  output logic              dwrValid,
  output logic              dwrMatch,
  output logic [DATA_W-1:0] cpuRdata
);

  localparam int TAG_W = ADDR_W - INDEX_W;
  localparam int LINES = 1 << INDEX_W;

  logic [DATA_W-1:0]  dataArr [LINES];
  logic [TAG_W-1:0]   tagArr  [LINES];
  logic [LINES-1:0]   lineValid;

  logic [ADDR_W-1:0]  dwrAddr;
  logic [DATA_W-1:0]  dwrData;

  logic [INDEX_W-1:0] reqIdx;
  logic [TAG_W-1:0]   reqTag;
  logic [INDEX_W-1:0] dwrIdx;
  logic [TAG_W-1:0]   dwrTag;
  logic [INDEX_W-1:0] wrIdx;
  logic [DATA_W-1:0]  wrData;

  assign reqIdx = cpuAddr[INDEX_W-1:0];
  assign reqTag = cpuAddr[ADDR_W-1:INDEX_W];
  assign dwrIdx = dwrAddr[INDEX_W-1:0];
  assign dwrTag = dwrAddr[ADDR_W-1:INDEX_W];

  // Tag compare for the request currently presented.
  assign lineHit  = lineValid[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign dwrMatch = dwrValid && (dwrAddr == cpuAddr);

  // Array write mux: pending store or returned fill word.
  assign wrIdx  = ctl.arrFromMem ? reqIdx   : dwrIdx;
  assign wrData = ctl.arrFromMem ? memRdata : dwrData;

  always_ff @(posedge clk) begin
    if (ctl.arrWr) dataArr[wrIdx] <= wrData;
    if (ctl.lineFill) tagArr[reqIdx] <= reqTag;
  end

  // One valid flag per line.
  for (genvar g = 0; g < LINES; g++) begin : gLineValid
    always_ff @(posedge clk) begin
      if (rst) begin
        lineValid[g] <= 1'b0;
      end else if (ctl.lineFill && (reqIdx == INDEX_W'(g))) begin
        lineValid[g] <= 1'b1;
      end
    end
  end

  // Delayed-write register.
  always_ff @(posedge clk) begin
    if (rst) begin
      dwrValid <= 1'b0;
    end else if (ctl.dwrLoad) begin
      dwrValid <= 1'b1;
    end else if (ctl.dwrClr) begin
      dwrValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.dwrLoad) begin
      dwrAddr <= cpuAddr;
      dwrData <= cpuWdata;
    end
  end

  // Loads see the pending store ahead of the array.
  assign cpuRdata = dwrMatch ? dwrData : dataArr[reqIdx];

  // R3
  dwr_load_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.dwrLoad |=> dwrValid);

  // R6
  dwr_resident_chk: assert property (@(posedge clk) disable iff (rst)
    dwrValid |-> (lineValid[dwrIdx] && (tagArr[dwrIdx] == dwrTag)));

endmodule

// File: rtl/spc_wbuf.sv
module spc_wbuf #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [DATA_W-1:0] pushData,
  input  logic              memAck,
  output logic              wbValid,
  output logic              wbRoom,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);

  logic drainAck;

  // While the buffer holds an entry, the only outstanding request is its write.
  assign drainAck = wbValid && memAck;
  assign wbRoom   = !wbValid || drainAck;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbValid <= 1'b0;
    end else if (push) begin
      wbValid <= 1'b1;
    end else if (drainAck) begin
      wbValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      wbAddr <= pushAddr;
      wbData <= pushData;
    end
  end

  // R10
  wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wbValid && !memAck) |=> (wbValid && $stable(wbAddr) && $stable(wbData)));

endmodule

// File: rtl/spc_control.sv
module spc_control
  import spc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuValid,
  input  logic       cpuWe,
  input  logic       lineHit,
  input  logic       dwrValid,
  input  logic       dwrMatch,
  input  logic       wbValid,
  input  logic       wbRoom,
  input  logic       memAck,
  output spcStrobe_t ctl,
  output logic       cpuReady,
  output logic       fillReq
);

  spcState_e state, stateNxt;

  always_comb begin
    ctl      = '0;
    cpuReady = 1'b0;
    fillReq  = 1'b0;
    stateNxt = state;
    unique case (state)
      ST_RUN: begin
        if (!cpuValid) begin
          cpuReady = 1'b1;
        end else if (lineHit) begin
          if (cpuWe) begin
            if (wbRoom) begin
              cpuReady    = 1'b1;
              ctl.dwrLoad = 1'b1;
              ctl.wbPush  = 1'b1;
              ctl.arrWr   = dwrValid;   // retire the older store
            end
          end else begin
            cpuReady = 1'b1;
            if (dwrMatch) begin
              ctl.arrWr  = 1'b1;         // bypass and retire together
              ctl.dwrClr = 1'b1;
            end
          end
        end else begin
          // Miss: empty the store pipeline before anything else.
          if (dwrValid) begin
            ctl.arrWr  = 1'b1;
            ctl.dwrClr = 1'b1;
          end
          stateNxt = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!wbValid) stateNxt = ST_FILL;
      end
      ST_FILL: begin
        fillReq = 1'b1;
        if (memAck) begin
          ctl.arrWr      = 1'b1;
          ctl.arrFromMem = 1'b1;
          ctl.lineFill   = 1'b1;
          stateNxt       = ST_RUN;
        end
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RUN;
    else     state <= stateNxt;
  end

  // R6
  miss_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN) |-> !dwrValid);

endmodule

// File: rtl/store_pipe_cache.sv
module store_pipe_cache
  import spc_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuValid,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);

  spcStrobe_t        ctl;
  logic              lineHit;
  logic              dwrValid;
  logic              dwrMatch;
  logic              wbValid;
  logic              wbRoom;
  logic              fillReq;
  logic [ADDR_W-1:0] wbAddr;
  logic [DATA_W-1:0] wbData;

  spc_control uCtrl (
    .clk      (clk),
    .rst      (rst),
    .cpuValid (cpuValid),
    .cpuWe    (cpuWe),
    .lineHit  (lineHit),
    .dwrValid (dwrValid),
    .dwrMatch (dwrMatch),
    .wbValid  (wbValid),
    .wbRoom   (wbRoom),
    .memAck   (memAck),
    .ctl      (ctl),
    .cpuReady (cpuReady),
    .fillReq  (fillReq)
  );

  spc_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .INDEX_W (INDEX_W)
  ) uDp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .memRdata (memRdata),
    .lineHit  (lineHit),
    .dwrValid (dwrValid),
    .dwrMatch (dwrMatch),
    .cpuRdata (cpuRdata)
  );

  spc_wbuf #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) uWb (
    .clk      (clk),
    .rst      (rst),
    .push     (ctl.wbPush),
    .pushAddr (cpuAddr),
    .pushData (cpuWdata),
    .memAck   (memAck),
    .wbValid  (wbValid),
    .wbRoom   (wbRoom),
    .wbAddr   (wbAddr),
    .wbData   (wbData)
  );

  // Lower-level port: fill reads only run once the buffer is empty.
  assign memReq   = fillReq || wbValid;
  assign memWe    = !fillReq;
  assign memAddr  = fillReq ? cpuAddr : wbAddr;
  assign memWdata = wbData;

  // R6
  fill_order_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memWe) |-> !wbValid);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr)
                             && (!memWe || $stable(memWdata))));

endmodule

// File: tb/store_pipe_cache_test.sv
`timescale 1ns/1ps
module store_pipe_cache_test;

  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int IW    = 4;
  localparam int WORDS = 1 << AW;
  localparam int LAT   = 2;
  localparam int NVEC  = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpuValid = 1'b0;
  logic          cpuWe = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic          cpuReady;
  logic [DW-1:0] cpuRdata;
  logic          memReq;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          memAck = 1'b0;
  logic [DW-1:0] memRdata = '0;

  always #2.5 clk = ~clk;   // 200 MHz

  store_pipe_cache #(.ADDR_W(AW), .DATA_W(DW), .INDEX_W(IW)) uut (
    .clk(clk), .rst(rst),
    .cpuValid(cpuValid), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  logic [DW-1:0] mainMem [WORDS];
  logic [DW-1:0] refMem  [WORDS];
  int memCnt = 0;
  int writeCnt = 0;
  int storeCnt = 0;
  int holdErr = 0;
  int total = 0;
  int fails = 0;

  // Lower-level memory: acknowledges LAT+1 edges after a request appears.
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      if (memCnt == LAT) begin
        memCnt <= 0;
        memAck <= 1'b1;
        if (memWe) begin
          mainMem[memAddr] <= memWdata;
          writeCnt <= writeCnt + 1;
        end else begin
          memRdata <= mainMem[memAddr];
        end
      end else begin
        memCnt <= memCnt + 1;
      end
    end
  end

  // Request stability monitor (R9).
  logic          prevPend = 1'b0;
  logic          prevWe = 1'b0;
  logic [AW-1:0] prevAddr = '0;
  always @(negedge clk) begin
    if (!rst && prevPend && (!memReq || memWe != prevWe || memAddr != prevAddr))
      holdErr <= holdErr + 1;
    prevPend <= !rst && memReq && !memAck;
    prevWe   <= memWe;
    prevAddr <= memAddr;
  end

  // Stimulus table: {store, address, data}; loads are compared with refMem.
  localparam logic [DW+AW:0] VEC [NVEC] = '{
    {1'b0, 10'd8,    32'h0},
    {1'b1, 10'd8,    32'h1111_0008},
    {1'b0, 10'd8,    32'h0},
    {1'b0, 10'd24,   32'h0},
    {1'b0, 10'd8,    32'h0},
    {1'b1, 10'd9,    32'h2222_0009},
    {1'b1, 10'd10,   32'h3333_000A},
    {1'b0, 10'd9,    32'h0},
    {1'b1, 10'd9,    32'h4444_0009},
    {1'b1, 10'd9,    32'h5555_0009},
    {1'b0, 10'd9,    32'h0},
    {1'b0, 10'd10,   32'h0},
    {1'b1, 10'd26,   32'h6666_001A},
    {1'b0, 10'd10,   32'h0},
    {1'b0, 10'd26,   32'h0},
    {1'b1, 10'd1023, 32'h7777_03FF},
    {1'b0, 10'd1023, 32'h0},
    {1'b0, 10'd15,   32'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; returns the stall count and load data.
  task automatic doOp(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output int waits, output logic [DW-1:0] rd);
    cpuValid = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d; waits = 0;
    #1;
    while (!cpuReady && waits < 1000) begin
      @(negedge clk); #1; waits++;
    end
    rd = cpuRdata;
    if (cpuReady && we) begin
      refMem[a] = d;
      storeCnt++;
    end
    @(negedge clk);
    cpuValid = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int w;
    logic [DW-1:0] rd;
    for (int i = 0; i < WORDS; i++) begin
      mainMem[i] = {16'hC0DE, 6'd0, i[9:0]};
      refMem[i]  = {16'hC0DE, 6'd0, i[9:0]};
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;

    // R1: idle state after reset
    chk(cpuReady == 1'b1, "R1 ready idle", {31'd0, cpuReady}, 32'd1);
    chk(memReq == 1'b0, "R1 memReq idle", {31'd0, memReq}, 32'd0);
    @(negedge clk);
    doOp(1'b0, 10'd5, '0, w, rd);
    chk(w > 0, "R1 first load misses", w, 32'd1);
    chk(rd == refMem[5], "R1 first load data", rd, refMem[5]);

    // R2: table walk, each load checked against the reference memory
    for (int i = 0; i < NVEC; i++) begin
      doOp(VEC[i][DW+AW], VEC[i][DW+AW-1:DW], VEC[i][DW-1:0], w, rd);
      if (!VEC[i][DW+AW])
        chk(rd == refMem[VEC[i][DW+AW-1:DW]], "R2 table load", rd,
            refMem[VEC[i][DW+AW-1:DW]]);
    end

    // R3: single-cycle store hit with an empty write buffer
    doOp(1'b0, 10'd40, '0, w, rd);
    doOp(1'b0, 10'd41, '0, w, rd);
    idle(8);
    doOp(1'b1, 10'd40, 32'hABCD_0040, w, rd);
    chk(w == 0, "R3 store hit stalls", w, 32'd0);

    // R4: immediate load of the pending store is forwarded without a stall
    doOp(1'b0, 10'd40, '0, w, rd);
    chk(w == 0, "R4 bypass stall", w, 32'd0);
    chk(rd == 32'hABCD_0040, "R4 bypass data", rd, 32'hABCD_0040);

    // R10: second store while the first write is still outstanding
    doOp(1'b1, 10'd41, 32'hABCD_0041, w, rd);
    chk(w > 0, "R10 store behind busy buffer", w, 32'd1);

    // R5: other-address load keeps the pending store intact
    doOp(1'b0, 10'd40, '0, w, rd);
    chk(rd == 32'hABCD_0040 && w == 0, "R5 other address load", rd, 32'hABCD_0040);
    doOp(1'b0, 10'd41, '0, w, rd);
    chk(rd == 32'hABCD_0041, "R5 pending value kept", rd, 32'hABCD_0041);

    // R6: pending store, then conflicting miss on the same line, then reload
    doOp(1'b0, 10'd57, '0, w, rd);
    idle(8);
    doOp(1'b1, 10'd57, 32'h5757_5757, w, rd);
    doOp(1'b0, 10'd73, '0, w, rd);
    chk(w > 0 && rd == refMem[73], "R6 conflicting miss", rd, refMem[73]);
    doOp(1'b0, 10'd57, '0, w, rd);
    chk(w > 0 && rd == 32'h5757_5757, "R6 reload after eviction", rd, 32'h5757_5757);

    // R7: store miss fills, retries and completes
    doOp(1'b1, 10'd200, 32'h2000_00C8, w, rd);
    chk(w > 0, "R7 store miss stalls", w, 32'd1);
    doOp(1'b0, 10'd200, '0, w, rd);
    chk(w == 0 && rd == 32'h2000_00C8, "R7 load after store miss", rd, 32'h2000_00C8);
    doOp(1'b0, 10'd216, '0, w, rd);
    doOp(1'b0, 10'd200, '0, w, rd);
    chk(rd == 32'h2000_00C8, "R7 value after eviction", rd, 32'h2000_00C8);

    // R8: write-through accounting and final memory image
    idle(20);
    chk(writeCnt == storeCnt, "R8 write count", writeCnt, storeCnt);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < WORDS; i++) if (mainMem[i] != refMem[i]) bad++;
      chk(bad == 0, "R8 memory image", bad, 32'd0);
    end

    // R9: request stability across the whole run
    chk(holdErr == 0, "R9 request held", holdErr, 32'd0);

    summary();
    $finish;
  end

endmodule